// File: doc/BRIEF.md
# Peripheral Security and Privilege Attribute Controller

This block holds the security configuration for a set of slave peripherals and internal memories. For each securable peripheral it keeps one secure bit and one privileged bit. For each internal memory it keeps a watermark length that sets the size of that memory's unprivileged area. Flash has two such lengths: the unprivileged area and the unprivileged-writable area. Each of two SRAMs has one. The firewall logic elsewhere in the chip uses the resulting attribute vectors and byte lengths. Software reaches the block over a simple single-cycle 32-bit register bus. Every access carries a secure flag and a privileged flag.

Writes to the secure-attribute register need a secure access. Every write needs a privileged access. One peripheral position, the radio SPI port, takes its secure attribute from a strap input instead of the register. A set-only lock bit freezes the attribute and watermark registers until reset. Reads are combinational and are always allowed.

Register map (byte addresses, word aligned): control at 0x00, secure attributes at 0x10, privileged attributes at 0x20, and watermark lengths at 0x30 (flash unprivileged), 0x34 (flash unprivileged-writable), 0x38 (SRAM1) and 0x3C (SRAM2).

Top module: `sec_attr_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted, every register reads zero, the lock is clear, and all attribute and watermark outputs are zero (apart from the strap-driven secure bit).
- R2: A write at address 0x10 with bus_sec=1 and bus_priv=1 stores the data into the secure-attribute register. The change shows on periph_sec_o and on readback after the next rising edge.
- R3: A write at address 0x10 with bus_sec=0 leaves the secure-attribute register unchanged. The register can still be read.
- R4: Only bit positions set in IMPL_MASK (default 0x00000FB7) are implemented. The other positions read zero, drive zero on both attribute outputs and ignore writes.
- R5: Bit STRAP_POS (default 2) of periph_sec_o always equals strap_in. The register bit at that position reads zero and ignores writes.
- R6: A write at address 0x20 with bus_priv=1 updates the privileged-attribute register whatever the value of bus_sec.
- R7: Any write with bus_priv=0 changes no register, including the lock.
- R8: A watermark register keeps its length in bits [14:8], and all other bits read zero. The byte-length output equals the stored value times 2048 for the two flash lengths and times 1024 for the SRAM lengths.
- R9: Writing 1 to bit 0 of the control register (0x00) with bus_sec=1 and bus_priv=1 sets the lock. The lock reads back in bit 0. Writing 0 never clears it, and a non-secure write never sets it.
- R10: While the lock is set, writes to the attribute and watermark registers are ignored. Reads and outputs keep their values until reset.
- R11: An unmapped or misaligned address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_sec | input | 1 | Access is from a secure context |
| bus_priv | input | 1 | Access is privileged |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| strap_in | input | 1 | Secure attribute for the strap-controlled peripheral |
| periph_sec_o | output | 32 | Per-peripheral secure attribute |
| periph_priv_o | output | 32 | Per-peripheral privileged attribute |
| wm_flash_unpriv_o | output | 18 | Flash unprivileged area length in bytes |
| wm_flash_unpriv_wr_o | output | 18 | Flash unprivileged-writable area length in bytes |
| wm_sram1_o | output | 18 | SRAM1 unprivileged area length in bytes |
| wm_sram2_o | output | 18 | SRAM2 unprivileged area length in bytes |
| lock_o | output | 1 | Configuration lock state |

## Verification
The strap input and a software write to the secure-attribute register can land on the same clock edge. Both then act on the same bit position. The bench provokes this by toggling strap_in in the very cycle that a secure write of all ones reaches address 0x10. The per-cycle reference model then requires the register bit to read zero while periph_sec_o follows the strap. A second collision follows straight after the lock is set: the write that sets the lock and the first blocked write come on consecutive edges, and the model judges whether that first write was refused.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 8;
  localparam int LGTH_W   = 7;
  localparam int LGTH_LSB = 8;
  localparam int NUM_WM   = 4;
  localparam int WMI_W    = $clog2(NUM_WM);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_SEC,
    SEL_PRIV,
    SEL_WM
  } reg_sel_e;

  // Address decode: word-aligned only; 0x00 ctrl, 0x10 sec, 0x20 priv, 0x30..0x3C watermarks
  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      case (a[7:4])
        4'h0: if (a[3:2] == 2'b00) s = SEL_CTRL;
        4'h1: if (a[3:2] == 2'b00) s = SEL_SEC;
        4'h2: if (a[3:2] == 2'b00) s = SEL_PRIV;
        4'h3: s = SEL_WM;
        default: s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // Place a granule count into its register field
  function automatic logic [REG_W-1:0] wm_word(input logic [LGTH_W-1:0] len);
    logic [REG_W-1:0] w;
    w = '0;
    w[LGTH_LSB +: LGTH_W] = len;
    return w;
  endfunction

  // Extract a granule count from a bus word
  function automatic logic [LGTH_W-1:0] wm_field(input logic [REG_W-1:0] w);
    return w[LGTH_LSB +: LGTH_W];
  endfunction
endpackage

// File: rtl/sac_bitcfg_reg.sv
module sac_bitcfg_reg #(
  parameter int             W    = 32,
  parameter logic [W-1:0]   MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d & MASK;
  end
endmodule

// File: rtl/sac_wm_bank.sv
module sac_wm_bank #(
  parameter int N  = 4,
  parameter int LW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we,
  input  logic [LW-1:0]   d,
  output logic [N*LW-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_wm
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i*LW +: LW] <= '0;
      else if (we[i]) q[i*LW +: LW] <= d;
    end
  end
endmodule

// File: rtl/sac_lock.sv
module sac_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
  end
endmodule

// File: rtl/sec_attr_ctrl.sv
module sec_attr_ctrl
  import sac_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK        = 32'h0000_0FB7,
  parameter int               STRAP_POS        = 2,
  parameter int               FLASH_GRAN_SHIFT = 11,
  parameter int               SRAM_GRAN_SHIFT  = 10,
  localparam int              WMB_W = LGTH_W +
      ((FLASH_GRAN_SHIFT > SRAM_GRAN_SHIFT) ? FLASH_GRAN_SHIFT : SRAM_GRAN_SHIFT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_sec,
  input  logic              bus_priv,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              strap_in,
  output logic [REG_W-1:0]  periph_sec_o,
  output logic [REG_W-1:0]  periph_priv_o,
  output logic [WMB_W-1:0]  wm_flash_unpriv_o,
  output logic [WMB_W-1:0]  wm_flash_unpriv_wr_o,
  output logic [WMB_W-1:0]  wm_sram1_o,
  output logic [WMB_W-1:0]  wm_sram2_o,
  output logic              lock_o
);
  localparam logic [REG_W-1:0] STRAP_BIT = REG_W'(1) << STRAP_POS;
  localparam logic [REG_W-1:0] SEC_MASK  = IMPL_MASK & ~STRAP_BIT;
  localparam int WM_SHIFT [NUM_WM] =
      '{FLASH_GRAN_SHIFT, FLASH_GRAN_SHIFT, SRAM_GRAN_SHIFT, SRAM_GRAN_SHIFT};

  // Named internal events for the checker
  reg_sel_e               hit;
  logic [WMI_W-1:0]       wm_idx;
  logic                   wr_req;
  logic                   cfg_wr_ok;
  logic                   sec_we;
  logic                   priv_we;
  logic                   lock_set;
  logic [NUM_WM-1:0]      wm_we;
  logic [REG_W-1:0]       sec_cfg;
  logic [REG_W-1:0]       priv_cfg;
  logic [NUM_WM*LGTH_W-1:0] wm_q;
  logic [WMB_W-1:0]       wm_bytes [NUM_WM];

  assign hit       = decode(bus_addr);
  assign wm_idx    = bus_addr[2 +: WMI_W];
  assign wr_req    = bus_sel & bus_wr & bus_priv;
  assign cfg_wr_ok = wr_req & ~lock_o;
  assign sec_we    = cfg_wr_ok & bus_sec & (hit == SEL_SEC);
  assign priv_we   = cfg_wr_ok & (hit == SEL_PRIV);
  assign lock_set  = wr_req & bus_sec & (hit == SEL_CTRL) & bus_wdata[0];

  always_comb begin
    for (int i = 0; i < NUM_WM; i++)
      wm_we[i] = cfg_wr_ok & (hit == SEL_WM) & (wm_idx == WMI_W'(i));
  end

  sac_bitcfg_reg #(.W(REG_W), .MASK(SEC_MASK)) u_sec_reg (
    .clk(clk), .rst_n(rst_n), .we(sec_we), .d(bus_wdata), .q(sec_cfg)
  );

  sac_bitcfg_reg #(.W(REG_W), .MASK(IMPL_MASK)) u_priv_reg (
    .clk(clk), .rst_n(rst_n), .we(priv_we), .d(bus_wdata), .q(priv_cfg)
  );

  sac_wm_bank #(.N(NUM_WM), .LW(LGTH_W)) u_wm (
    .clk(clk), .rst_n(rst_n), .we(wm_we), .d(wm_field(bus_wdata)), .q(wm_q)
  );

  sac_lock u_lock (
    .clk(clk), .rst_n(rst_n), .set(lock_set), .q(lock_o)
  );

  // Granule counts expanded to byte lengths
  for (genvar i = 0; i < NUM_WM; i++) begin : g_bytes
    assign wm_bytes[i] = WMB_W'(wm_q[i*LGTH_W +: LGTH_W]) << WM_SHIFT[i];
  end

  assign wm_flash_unpriv_o    = wm_bytes[0];
  assign wm_flash_unpriv_wr_o = wm_bytes[1];
  assign wm_sram1_o           = wm_bytes[2];
  assign wm_sram2_o           = wm_bytes[3];

  assign periph_sec_o  = sec_cfg | (strap_in ? STRAP_BIT : '0);
  assign periph_priv_o = priv_cfg;

  always_comb begin
    case (hit)
      SEL_CTRL: bus_rdata = {{(REG_W-1){1'b0}}, lock_o};
      SEL_SEC:  bus_rdata = sec_cfg;
      SEL_PRIV: bus_rdata = priv_cfg;
      SEL_WM:   bus_rdata = wm_word(wm_q[wm_idx*LGTH_W +: LGTH_W]);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sec_attr_ctrl_chk.sv
module sec_attr_ctrl_chk
  import sac_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL_MASK = 32'h0000_0FB7,
  parameter int               STRAP_POS = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_sel,
  input logic                     bus_wr,
  input logic                     bus_sec,
  input logic                     bus_priv,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic                     strap_in,
  input logic                     lock_o,
  input logic [REG_W-1:0]         periph_sec_o,
  input logic [REG_W-1:0]         periph_priv_o,
  input logic [REG_W-1:0]         sec_cfg,
  input logic [REG_W-1:0]         priv_cfg,
  input logic [NUM_WM*LGTH_W-1:0] wm_q
);
  AST_SEC_NEEDS_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_sec && decode(bus_addr) == SEL_SEC) |=> $stable(sec_cfg)); // R3

  AST_UNPRIV_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !bus_priv) |=>
      ($stable(sec_cfg) && $stable(priv_cfg) && $stable(wm_q) && $stable(lock_o))); // R7

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> lock_o); // R9

  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    lock_o |=> ($stable(sec_cfg) && $stable(priv_cfg) && $stable(wm_q))); // R10

  AST_STRAP_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    periph_sec_o[STRAP_POS] == strap_in); // R5

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((periph_sec_o | periph_priv_o) & ~IMPL_MASK) == '0); // R4
endmodule

bind sec_attr_ctrl sec_attr_ctrl_chk #(
  .IMPL_MASK(IMPL_MASK),
  .STRAP_POS(STRAP_POS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_sec(bus_sec), .bus_priv(bus_priv), .bus_addr(bus_addr),
  .strap_in(strap_in), .lock_o(lock_o), .periph_sec_o(periph_sec_o),
  .periph_priv_o(periph_priv_o), .sec_cfg(sec_cfg), .priv_cfg(priv_cfg),
  .wm_q(wm_q)
);

// File: tb/sec_attr_ctrl_bench.sv
`timescale 1ns/1ps
module sec_attr_ctrl_bench;
  localparam logic [31:0] MASK  = 32'h0000_0FB7;
  localparam int          STRAP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_sec = 1'b0, bus_priv = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic        strap_in = 1'b0;
  logic [31:0] bus_rdata, periph_sec_o, periph_priv_o;
  logic [17:0] wm0, wm1, wm2, wm3;
  logic        lock_o;

  always #4 clk = ~clk;

  sec_attr_ctrl #(.IMPL_MASK(MASK), .STRAP_POS(STRAP)) u_sec_attr_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_sec(bus_sec),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .strap_in(strap_in),
    .periph_sec_o(periph_sec_o), .periph_priv_o(periph_priv_o),
    .wm_flash_unpriv_o(wm0), .wm_flash_unpriv_wr_o(wm1),
    .wm_sram1_o(wm2), .wm_sram2_o(wm3), .lock_o(lock_o)
  );

  // Behavioural reference model
  logic [31:0] m_sec, m_priv;
  int          m_wm [4];
  bit          m_lock;
  int          vectors = 0, fails = 0;
  string       cur_req = "R1";
  bit          done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_priv = 0; m_lock = 0;
      foreach (m_wm[k]) m_wm[k] = 0;
    end else if (bus_sel && bus_wr && bus_priv) begin
      int a;
      a = bus_addr;
      if (a == 0) begin
        if (bus_sec && bus_wdata[0]) m_lock = 1;
      end else if (!m_lock) begin
        if (a == 16 && bus_sec) m_sec = bus_wdata & MASK & ~(32'd1 << STRAP);
        else if (a == 32) m_priv = bus_wdata & MASK;
        else if (a >= 48 && a <= 60 && a % 4 == 0) m_wm[(a - 48) / 4] = (bus_wdata / 256) % 128;
      end
    end
  end

  function automatic logic [31:0] m_read(input int a);
    if (a == 0) return {31'd0, m_lock};
    if (a == 16) return m_sec;
    if (a == 32) return m_priv;
    if (a >= 48 && a <= 60 && a % 4 == 0) return m_wm[(a - 48) / 4] * 256;
    return 0;
  endfunction

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      cmp("rdata", bus_rdata, m_read(bus_addr));
      cmp("sec_out", periph_sec_o, m_sec | (strap_in ? (32'd1 << STRAP) : 32'd0));
      cmp("priv_out", periph_priv_o, m_priv);
      cmp("wm_flash_up", 32'(wm0), m_wm[0] * 2048);
      cmp("wm_flash_upw", 32'(wm1), m_wm[1] * 2048);
      cmp("wm_sram1", 32'(wm2), m_wm[2] * 1024);
      cmp("wm_sram2", 32'(wm3), m_wm[3] * 1024);
      cmp("lock", 32'(lock_o), 32'(m_lock));
    end
  end

  task automatic drive(input bit s, input bit w, input logic [7:0] a, input logic [31:0] d,
                       input bit sc, input bit pv);
    @(posedge clk); #2;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; bus_sec = sc; bus_priv = pv;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit sc, input bit pv);
    drive(1, 1, a, d, sc, pv);
  endtask

  task automatic rd(input logic [7:0] a);
    drive(1, 0, a, 32'h0, 0, 0);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(8'h00); rd(8'h10); rd(8'h20); rd(8'h30);

    cur_req = "R3";
    wr(8'h10, 32'hFFFF_FFFF, 0, 1); rd(8'h10);

    cur_req = "R2";
    wr(8'h10, 32'h0000_0005, 1, 1); rd(8'h10);
    cur_req = "R4";
    wr(8'h10, 32'hFFFF_FFFF, 1, 1); rd(8'h10);

    cur_req = "R5";
    strap_in = 1'b1; rd(8'h10);
    // strap toggle lands on the same edge as a secure write of all ones
    @(posedge clk); #2;
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'hFFFF_FFFF;
    bus_sec = 1; bus_priv = 1; strap_in = 1'b0;
    rd(8'h10);
    strap_in = 1'b1; wr(8'h10, 32'h0000_0004, 1, 1); rd(8'h10);

    cur_req = "R6";
    wr(8'h20, 32'hFFFF_FFFF, 0, 1); rd(8'h20);
    wr(8'h20, 32'h0000_00A5, 1, 1); rd(8'h20);

    cur_req = "R7";
    wr(8'h20, 32'h0000_0F00, 1, 0); rd(8'h20);
    wr(8'h10, 32'h0000_0000, 1, 0); rd(8'h10);
    wr(8'h30, 32'h0000_7F00, 1, 0); rd(8'h30);
    wr(8'h00, 32'h0000_0001, 1, 0); rd(8'h00);

    cur_req = "R8";
    wr(8'h30, 32'hFFFF_FFFF, 0, 1); rd(8'h30);
    wr(8'h34, 32'h0000_0300, 0, 1); rd(8'h34);
    wr(8'h38, 32'h0000_4500, 1, 1); rd(8'h38);
    wr(8'h3C, 32'h1234_0100, 1, 1); rd(8'h3C);

    cur_req = "R11";
    wr(8'h50, 32'hFFFF_FFFF, 1, 1); rd(8'h50);
    wr(8'h12, 32'hFFFF_FFFF, 1, 1); rd(8'h12);
    wr(8'h14, 32'hFFFF_FFFF, 1, 1); rd(8'h14); rd(8'hFC);

    cur_req = "R9";
    wr(8'h00, 32'h0000_0001, 0, 1); rd(8'h00);
    wr(8'h00, 32'hFFFF_FFFE, 1, 1); rd(8'h00);
    wr(8'h00, 32'h0000_0001, 1, 1);
    cur_req = "R10";
    wr(8'h20, 32'h0000_0000, 1, 1); rd(8'h20);
    wr(8'h10, 32'h0000_0000, 1, 1); rd(8'h10);
    wr(8'h34, 32'h0000_0000, 1, 1); rd(8'h34);
    wr(8'h38, 32'h0000_7F00, 0, 1); rd(8'h38);
    cur_req = "R9";
    wr(8'h00, 32'h0000_0000, 1, 1); rd(8'h00);
    strap_in = 1'b0; rd(8'h10);

    cur_req = "R1";
    @(posedge clk); #2 rst_n = 1'b0; bus_sel = 0; bus_wr = 0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(8'h00); rd(8'h20); rd(8'h3C);

    cur_req = "R2";
    wr(8'h10, 32'h0000_0880, 1, 1); rd(8'h10);
    drive(0, 0, 8'h00, 32'h0, 0, 0);
    @(posedge clk); #5;
    done = 1;
    summary();
    $finish;
  end
endmodule